// File: doc/BRIEF.md
# Single-Chamber Inhibited Pacing Timer

This block is the escape-interval controller for one heart chamber running in inhibited mode. It watches a digital sense input and issues a pace pulse only when no natural beat arrives in time. All timing is counted on a one-millisecond tick enable (`tick_ms`). Two programmable intervals set the behaviour: the lower-rate interval (the longest allowed gap between chamber events) and the upper-rate interval (the shortest allowed gap). Both are given in milliseconds.

After any chamber event, sensed or paced, the controller enters a hold window that lasts for the upper-rate interval. Senses are ignored during this window. It then opens a watch window. A sense in the watch window restarts the cycle with no pace. If the watch window expires, the controller paces at once. The first escape window after reset is the full lower-rate interval. Every later watch window is the lower-rate interval minus the upper-rate interval, because the hold window already used up the rest. The state code and the sense-enable flag are exported for the chamber's sense front end. All pins are plain control levels or pulses. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `escape_pacer`

## Requirements
- R1: A synchronous reset sets the state code to 00 (free-running start), holds `sense_en` high and `pace_out` low, clears the tick counter, and captures both interval inputs.
- R2: In the start state (code 00), if no sense arrives, `pace_out` pulses on the clock after the tick that completes the lower-rate interval. The block then enters the hold state (code 01).
- R3: In the hold state `sense_en` is low. After exactly the captured upper-rate interval in ticks, the block moves to the watch state (code 10) with `sense_en` high.
- R4: In the watch state, the escape timeout is the lower-rate interval minus the upper-rate interval. With no senses at all, consecutive paces are therefore spaced exactly the lower-rate interval apart in ticks.
- R5: A sense while `sense_en` is high (code 00 or 10) moves the block to the hold state with no pace. The next pace comes one lower-rate interval of ticks after that sense, unless another sense arrives first.
- R6: A sense while `sense_en` is low has no effect on the state, the timer or the pace output.
- R7: If a sense and the expiring tick arrive in the same clock, the sense wins: no pace is issued and the block enters the hold state.
- R8: `pace_out` is high for exactly one clock per pace.
- R9: The interval inputs are captured at reset and at every chamber event. A change to them takes effect from the next event onward.
- R10: With legal settings (lower-rate interval > upper-rate interval ≥ 1), the spacing between consecutive chamber events is never less than the upper-rate interval and never more than the lower-rate interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_ms | input | 1 | One-clock enable, once per millisecond |
| sense_in | input | 1 | Detected natural beat in the chamber |
| lri_ms | input | IV_W | Lower-rate interval in ms |
| uri_ms | input | IV_W | Upper-rate interval in ms |
| pace_out | output | 1 | One-clock pace request |
| state_code | output | 2 | 00 start, 01 hold, 10 watch |
| sense_en | output | 1 | High when senses are acted on |

## Verification
The controller is driven with several input patterns:
- **No senses at all.** This shows whether the first window is the full lower-rate interval and whether later watch windows are shortened by the hold time.
- **A sense inside the watch window.** This shows whether the escape timer restarts from the sense rather than from the last pace.
- **A sense inside the hold window.** This separates a sense that is ignored from one that resets the timer.
- **A sense on the same clock as the expiring tick.** This shows which of the two wins.
- **An interval change in mid-cycle.** This shows whether the new value is applied at once or only at the next event.
- **A reset followed by a sense early in the start window.** This checks how the first window behaves in both cases.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  typedef enum logic [1:0] {
    ST_FREE  = 2'b00,
    ST_HOLD  = 2'b01,
    ST_WATCH = 2'b10
  } pstate_t;
endpackage

// File: rtl/ms_interval_timer.sv
module ms_interval_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign expire  = tick && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (tick)      cnt_q <= cnt_inc[CNT_W-1:0];
  end

  // counter never runs past the active window length
  p_cnt_in_window_r3: assert property (@(posedge clk) disable iff (rst)
    (limit != '0) |-> (cnt_q < limit));
  // R1: timer starts from zero after reset
  p_cnt_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt_q == '0));
endmodule

// File: rtl/pace_ctrl_fsm.sv
module pace_ctrl_fsm
  import pacer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       sense_in,
  input  logic       expire,
  output pstate_t    st,
  output logic       restart,
  output logic       chamber_evt,
  output logic       pace_q,
  output logic       sense_en
);
  pstate_t st_nxt;
  logic    pace_d;

  always_comb begin
    st_nxt      = st;
    chamber_evt = 1'b0;
    pace_d      = 1'b0;
    case (st)
      ST_FREE, ST_WATCH: begin
        if (sense_in) begin
          st_nxt      = ST_HOLD;
          chamber_evt = 1'b1;
        end else if (expire) begin
          st_nxt      = ST_HOLD;
          chamber_evt = 1'b1;
          pace_d      = 1'b1;
        end
      end
      ST_HOLD: if (expire) st_nxt = ST_WATCH;
      default: st_nxt = ST_FREE;
    endcase
  end

  assign restart  = (st_nxt != st);
  assign sense_en = (st != ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_FREE;
      pace_q <= 1'b0;
    end else begin
      st     <= st_nxt;
      pace_q <= pace_d;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (st == ST_FREE && !pace_q));
  p_pace_enters_hold_r2: assert property (@(posedge clk) disable iff (rst)
    pace_q |-> (st == ST_HOLD));
  p_hold_exit_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == ST_HOLD && st == ST_WATCH) |-> $past(tick));
  p_sense_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD && !tick) |=> (st == ST_HOLD && !pace_q));
  p_sense_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (sense_en && sense_in) |=> (!pace_q && st == ST_HOLD));
  p_pace_single_r8: assert property (@(posedge clk) disable iff (rst)
    pace_q |=> !pace_q);
endmodule

// File: rtl/escape_pacer.sv
module escape_pacer
  import pacer_pkg::*;
#(
  parameter int IV_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_ms,
  input  logic            sense_in,
  input  logic [IV_W-1:0] lri_ms,
  input  logic [IV_W-1:0] uri_ms,
  output logic            pace_out,
  output logic [1:0]      state_code,
  output logic            sense_en
);
  pstate_t         st;
  logic            restart, chamber_evt, expire;
  logic [IV_W-1:0] lri_q, uri_q, win_len;

  // interval capture at reset and at each chamber event (R9)
  always_ff @(posedge clk) begin
    if (rst || chamber_evt) begin
      lri_q <= lri_ms;
      uri_q <= uri_ms;
    end
  end

  always_comb begin
    case (st)
      ST_HOLD:  win_len = uri_q;
      ST_WATCH: win_len = lri_q - uri_q;
      default:  win_len = lri_q;
    endcase
  end

  ms_interval_timer #(.CNT_W(IV_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick    (tick_ms),
    .limit   (win_len),
    .expire  (expire)
  );

  pace_ctrl_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick_ms),
    .sense_in    (sense_in),
    .expire      (expire),
    .st          (st),
    .restart     (restart),
    .chamber_evt (chamber_evt),
    .pace_q      (pace_out),
    .sense_en    (sense_en)
  );

  assign state_code = st;

  // R9: captured intervals hold steady between events
  p_iv_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(chamber_evt) && !$past(rst) |-> ($stable(lri_q) && $stable(uri_q)));
endmodule

// File: tb/tb_escape_pacer.sv
`timescale 1ns/1ps
module tb_escape_pacer;
  localparam int IV_W = 12;
  localparam int TDIV = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            tick_ms = 1'b0;
  logic            sense_in = 1'b0;
  logic [IV_W-1:0] lri_ms = 12'd20;
  logic [IV_W-1:0] uri_ms = 12'd8;
  logic            pace_out;
  logic [1:0]      state_code;
  logic            sense_en;

  int checks = 0;
  int errors = 0;
  int tick_no = 0;
  int exp_q[$];
  logic pace_prev = 1'b0;

  always #2 clk = ~clk;

  escape_pacer #(.IV_W(IV_W)) dut (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .sense_in(sense_in),
    .lri_ms(lri_ms), .uri_ms(uri_ms), .pace_out(pace_out),
    .state_code(state_code), .sense_en(sense_en)
  );

  // scoreboard monitor: each pace pops one expected tick number
  always @(negedge clk) begin
    if (!rst) begin
      if (pace_out) begin
        checks++;
        if (pace_prev) begin
          errors++;
          $display("FAIL R8 pace high two clocks: act=11 exp=10");
        end else if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R5/R6/R7 unexpected pace at tick act=%0d exp=none", tick_no);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (e != tick_no) begin
            errors++;
            $display("FAIL R2/R4 pace tick act=%0d exp=%0d", tick_no, e);
          end
        end
      end
      pace_prev <= pace_out;
    end else pace_prev <= 1'b0;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic one_tick(input logic with_sense);
    @(negedge clk);
    tick_ms = 1'b1;
    sense_in = with_sense;
    tick_no++;
    @(negedge clk);
    tick_ms = 1'b0;
    sense_in = 1'b0;
    repeat (TDIV - 2) @(negedge clk);
  endtask

  task automatic run_to(input int target);
    while (tick_no < target) one_tick(1'b0);
  endtask

  task automatic sense_only();
    @(negedge clk);
    sense_in = 1'b1;
    @(negedge clk);
    sense_in = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    do_reset();
    chk("R1 state code", state_code, 0);
    chk("R1 sense_en", sense_en, 1);
    chk("R1 pace_out", pace_out, 0);

    exp_q.push_back(20);            // R2 first window = full lower-rate interval
    run_to(20);
    chk("R3 hold state", state_code, 1);
    chk("R3 sense_en low in hold", sense_en, 0);
    run_to(27);
    chk("R3 still hold before uri", state_code, 1);
    run_to(28);
    chk("R3 watch after uri", state_code, 2);
    chk("R3 sense_en high in watch", sense_en, 1);

    exp_q.push_back(40);            // R4 watch window lri-uri
    run_to(40);

    run_to(52);
    sense_only();                   // R5 sense in watch
    chk("R5 sense enters hold", state_code, 1);
    exp_q.push_back(72);
    run_to(72);

    run_to(75);
    sense_only();                   // R6 sense in hold ignored
    chk("R6 state after ignored sense", state_code, 1);
    chk("R6 sense_en after ignored sense", sense_en, 0);
    exp_q.push_back(92);
    run_to(92);

    run_to(111);
    one_tick(1'b1);                 // R7 sense with expiring tick 112
    chk("R7 hold after tie", state_code, 1);
    exp_q.push_back(132);
    run_to(115);
    lri_ms = 12'd30;                // R9 change mid-cycle
    run_to(132);
    exp_q.push_back(162);           // R9 new lri from event 132 on
    run_to(162);

    do_reset();
    chk("R1 state after mid-run reset", state_code, 0);
    chk("R1 sense_en after reset", sense_en, 1);
    base = tick_no;
    exp_q.push_back(base + 30);
    run_to(base + 30);

    do_reset();
    base = tick_no;
    run_to(base + 5);
    sense_only();                   // R5 sense in start window
    exp_q.push_back(base + 35);     // R10 spacing = lri after sense
    run_to(base + 40);

    chk("R10 all expected paces seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule